// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the digital mode controller for a bus transceiver that carries its own supply regulator. It keeps track of five operating modes: unpowered, fail-safe, normal, silent and sleep. From these it drives the enables for the transmit path, the receive path, the regulator, the slave termination and the weak bus pull-up. It also produces an active-low reset for the host controller. The analog parts (comparators, regulator and bus driver) are not in this block. Their decisions reach it as clean digital flags, and a wake strobe comes from a separate bus-wake detector.

The host chooses a low-power mode by pulling the enable pin low. The level of the transmit-data pin then selects the mode: high selects silent and low selects sleep. The controller does not read that level at the moment the falling edge is detected. It reads the value from a configurable number of clock cycles earlier, and this lag acts as the mode-select window. While the controller is in fail-safe mode, the transmit pin becomes an output. Together with a forced level on the receive pin, it tells the host why fail-safe mode was entered.

All time intervals are counted in ticks of an external microsecond strobe. Setting the tick parameters to small values gives short intervals.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While unpowered, the supply-above flag moves the block to fail-safe mode. In that mode the regulator and the termination are on, the transmit pin is an output driven high (cause code "supply" = 1), and the receive pin is forced low.
- R2: From any powered mode, the supply-below flag moves the block to unpowered mode on the next clock. In unpowered mode the regulator, termination, pull-up, transmit path and receive path are all off, and the reset output is low.
- R3: The reset output rises only after the regulator has been on, with no undervoltage, for RST_TICKS consecutive ticks.
- R4: A regulator undervoltage that lasts fewer than DEB_TICKS ticks has no effect. One that lasts longer drives the reset output low. In normal or silent mode it also forces fail-safe mode with cause code "supply" (transmit pin high).
- R5: In fail-safe mode, enable high moves the block to normal mode only while the reset output is high. While the reset output is low, the block stays in fail-safe mode.
- R6: In normal mode, a falling edge of enable with the sampled transmit level high enters silent mode. In silent mode the transmit path and termination are off, the weak pull-up and regulator are on, and the receive pin is forced high.
- R7: In normal mode, a falling edge of enable with the sampled transmit level low enters sleep mode. In sleep mode the regulator and termination are off, the weak pull-up is on, and the reset output and receive pin are held low.
- R8: A wake strobe in silent or sleep mode moves the block to fail-safe mode with cause code "wake". The termination is turned back on, the transmit pin is driven low and the receive pin is forced low. Leaving sleep this way also turns the regulator back on and restarts the reset stretch.
- R9: In normal mode the transmit and receive paths and the termination are on. The transmit pin is an input and no receive level is forced.
- R10: The transmit level used for mode selection is the synchronised value from SEL_LAG cycles before the enable edge is detected. If transmit data falls together with enable, silent mode is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| en_pin | input | 1 | Enable pin level (asynchronous) |
| txd_pin | input | 1 | Transmit-data pin level (asynchronous) |
| vs_above | input | 1 | Supply above the power-on threshold |
| vs_below | input | 1 | Supply below the power-off threshold |
| vcc_uv | input | 1 | Regulator output undervoltage |
| wake_evt | input | 1 | Bus wake strobe from the detector |
| tx_path_en | output | 1 | Transmit path enable |
| rx_path_en | output | 1 | Receive path enable |
| reg_en | output | 1 | Regulator enable |
| term_en | output | 1 | Slave termination enable |
| weak_pu_en | output | 1 | Weak bus pull-up enable |
| rst_out_n | output | 1 | Active-low reset to the host |
| txd_oe | output | 1 | Transmit pin turned around to output |
| txd_drv | output | 1 | Level driven on the transmit pin when txd_oe is high |
| rxd_force | output | 1 | Receive pin level overridden |
| rxd_drv | output | 1 | Forced receive level when rxd_force is high |

## Verification
The bench drives the tick on every cycle and builds the block with RST_TICKS=40, DEB_TICKS=5 and SEL_LAG=3. With these values the whole reset stretch fits in a few dozen cycles, so the run can check both sides of its end: the reset is still low shortly before the stretch finishes and high after it. A three-cycle undervoltage glitch falls below the five-tick debounce, while a twenty-cycle one exceeds it, so both the ignored and the accepted case are observed. The three-cycle lag is long enough that enable and transmit data can fall in the same cycle and still select silent mode.

// File: rtl/xcvr_mode_pkg.sv
// Shared types for the transceiver mode controller.
// Assumes: nothing beyond SystemVerilog enums.
package xcvr_mode_pkg;

    typedef enum logic [2:0] {
        M_UNPOW    = 3'd0,
        M_FAILSAFE = 3'd1,
        M_NORMAL   = 3'd2,
        M_SILENT   = 3'd3,
        M_SLEEP    = 3'd4
    } xmc_mode_e;

    // Fail-safe entry cause; the value is the level driven on the transmit pin.
    typedef enum logic {
        CAUSE_WAKE   = 1'b0,
        CAUSE_SUPPLY = 1'b1
    } xmc_cause_e;

endpackage

// File: rtl/xmc_sync.sv
// Two-stage synchroniser for a bundle of asynchronous pin levels.
// Assumes: each bit is an independent quasi-static level; INIT is the idle level.
module xmc_sync #(
    parameter int          W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two flops in series per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;

endmodule

// File: rtl/xmc_sel_window.sv
// Enable falling-edge detector with a delayed view of transmit data.
// The transmit level reported with the edge is the synchronised value from
// LAG cycles earlier, which models the mode-select window.
// Assumes: en_s and txd_s come from the same synchroniser latency.
module xmc_sel_window #(
    parameter int LAG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic txd_s,
    output logic en_fall,
    output logic txd_pick
);

    logic en_q;

    // Previous synchronised enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_s;
    end

    assign en_fall = en_q & ~en_s;

    generate
        if (LAG == 0) begin : g_nolag
            assign txd_pick = txd_s;
        end else begin : g_lag
            logic [LAG-1:0] hist_q;

            // Shift history of transmit data; bit i holds the value i+1 cycles old.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q <= '1;
                end else begin
                    for (int i = LAG - 1; i > 0; i--) begin
                        hist_q[i] <= hist_q[i-1];
                    end
                    hist_q[0] <= txd_s;
                end
            end

            assign txd_pick = hist_q[LAG-1];
        end
    endgenerate

endmodule

// File: rtl/xmc_rst_gen.sv
// Host reset generator: debounces regulator undervoltage before pulling the
// reset low, and stretches the release until the regulator has been good
// for RST_TICKS consecutive ticks.
// Assumes: vcc_uv is a clean synchronous flag; tick is a one-cycle strobe.
module xmc_rst_gen #(
    parameter int RST_TICKS = 4000,
    parameter int DEB_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reg_on,
    input  logic vcc_uv,
    output logic rst_out_n
);

    localparam int RW = $clog2(RST_TICKS + 1);
    localparam int DW = $clog2(DEB_TICKS + 1);
    localparam logic [RW-1:0] RST_LAST = RW'(RST_TICKS - 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_TICKS - 1);

    logic [RW-1:0] good_cnt;
    logic [DW-1:0] uv_cnt;
    logic          nres_q;

    // Reset output state with debounce on assertion and stretch on release.
    always_ff @(posedge clk) begin
        if (!rst_n || !reg_on) begin
            nres_q   <= 1'b0;
            good_cnt <= '0;
            uv_cnt   <= '0;
        end else if (vcc_uv) begin
            good_cnt <= '0;
            if (nres_q && tick) begin
                if (uv_cnt == DEB_LAST) begin
                    nres_q <= 1'b0;
                    uv_cnt <= '0;
                end else begin
                    uv_cnt <= uv_cnt + 1'b1;
                end
            end
        end else begin
            uv_cnt <= '0;
            if (!nres_q && tick) begin
                if (good_cnt == RST_LAST) nres_q <= 1'b1;
                else                      good_cnt <= good_cnt + 1'b1;
            end
        end
    end

    assign rst_out_n = nres_q;

endmodule

// File: rtl/xmc_fsm.sv
// Operating mode state machine and output decode.
// Assumes: en_s synchronised, en_fall/txd_pick from the select window,
// rst_ok is the registered host reset level, supply flags are synchronous.
module xmc_fsm
    import xcvr_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vs_above,
    input  logic vs_below,
    input  logic wake_evt,
    input  logic en_s,
    input  logic en_fall,
    input  logic txd_pick,
    input  logic rst_ok,
    output logic tx_path_en,
    output logic rx_path_en,
    output logic reg_en,
    output logic term_en,
    output logic weak_pu_en,
    output logic txd_oe,
    output logic txd_drv,
    output logic rxd_force,
    output logic rxd_drv
);

    xmc_mode_e  st_q, st_d;
    xmc_cause_e cause_q, cause_d;

    // Next mode; a supply drop outranks every other condition.
    always_comb begin
        st_d    = st_q;
        cause_d = cause_q;
        if (st_q != M_UNPOW && vs_below) begin
            st_d = M_UNPOW;
        end else begin
            case (st_q)
                M_UNPOW: begin
                    if (vs_above) begin
                        st_d    = M_FAILSAFE;
                        cause_d = CAUSE_SUPPLY;
                    end
                end
                M_FAILSAFE: begin
                    if (rst_ok && en_s) st_d = M_NORMAL;
                end
                M_NORMAL: begin
                    if (!rst_ok) begin
                        st_d    = M_FAILSAFE;
                        cause_d = CAUSE_SUPPLY;
                    end else if (en_fall) begin
                        st_d = txd_pick ? M_SILENT : M_SLEEP;
                    end
                end
                M_SILENT: begin
                    if (!rst_ok) begin
                        st_d    = M_FAILSAFE;
                        cause_d = CAUSE_SUPPLY;
                    end else if (wake_evt) begin
                        st_d    = M_FAILSAFE;
                        cause_d = CAUSE_WAKE;
                    end
                end
                M_SLEEP: begin
                    if (wake_evt) begin
                        st_d    = M_FAILSAFE;
                        cause_d = CAUSE_WAKE;
                    end
                end
                default: st_d = M_UNPOW;
            endcase
        end
    end

    // Mode and cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= M_UNPOW;
            cause_q <= CAUSE_SUPPLY;
        end else begin
            st_q    <= st_d;
            cause_q <= cause_d;
        end
    end

    assign tx_path_en = (st_q == M_NORMAL);
    assign rx_path_en = (st_q == M_NORMAL);
    assign reg_en     = (st_q == M_FAILSAFE) || (st_q == M_NORMAL) || (st_q == M_SILENT);
    assign term_en    = (st_q == M_FAILSAFE) || (st_q == M_NORMAL);
    assign weak_pu_en = (st_q == M_SILENT) || (st_q == M_SLEEP);
    assign txd_oe     = (st_q == M_FAILSAFE);
    assign txd_drv    = (cause_q == CAUSE_SUPPLY);
    assign rxd_force  = (st_q == M_FAILSAFE) || (st_q == M_SILENT) || (st_q == M_SLEEP);
    assign rxd_drv    = (st_q == M_SILENT);

endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Top of the transceiver mode controller: synchronises the host pins, finds
// the enable edge with its windowed transmit sample, runs the mode machine
// and generates the host reset.
// Assumes: us_tick is a one-cycle strobe in the clk domain.
module xcvr_mode_ctrl #(
    parameter int RST_TICKS = 4000,
    parameter int DEB_TICKS = 8,
    parameter int SEL_LAG   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic en_pin,
    input  logic txd_pin,
    input  logic vs_above,
    input  logic vs_below,
    input  logic vcc_uv,
    input  logic wake_evt,
    output logic tx_path_en,
    output logic rx_path_en,
    output logic reg_en,
    output logic term_en,
    output logic weak_pu_en,
    output logic rst_out_n,
    output logic txd_oe,
    output logic txd_drv,
    output logic rxd_force,
    output logic rxd_drv
);

    logic [1:0] pins_s;
    logic       en_s, txd_s, en_fall, txd_pick, rst_ok;

    xmc_sync #(.W(2), .INIT(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({en_pin, txd_pin}),
        .d_out (pins_s)
    );

    assign en_s  = pins_s[1];
    assign txd_s = pins_s[0];

    xmc_sel_window #(.LAG(SEL_LAG)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (en_s),
        .txd_s    (txd_s),
        .en_fall  (en_fall),
        .txd_pick (txd_pick)
    );

    xmc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vs_above   (vs_above),
        .vs_below   (vs_below),
        .wake_evt   (wake_evt),
        .en_s       (en_s),
        .en_fall    (en_fall),
        .txd_pick   (txd_pick),
        .rst_ok     (rst_ok),
        .tx_path_en (tx_path_en),
        .rx_path_en (rx_path_en),
        .reg_en     (reg_en),
        .term_en    (term_en),
        .weak_pu_en (weak_pu_en),
        .txd_oe     (txd_oe),
        .txd_drv    (txd_drv),
        .rxd_force  (rxd_force),
        .rxd_drv    (rxd_drv)
    );

    xmc_rst_gen #(.RST_TICKS(RST_TICKS), .DEB_TICKS(DEB_TICKS)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (us_tick),
        .reg_on    (reg_en),
        .vcc_uv    (vcc_uv),
        .rst_out_n (rst_ok)
    );

    assign rst_out_n = rst_ok;

endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
// Property checker for the mode controller, attached by bind.
// Assumes: only top-level ports are observed.
module xcvr_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic vs_below,
    input logic vcc_uv,
    input logic tx_path_en,
    input logic reg_en,
    input logic term_en,
    input logic weak_pu_en,
    input logic rst_out_n,
    input logic txd_oe,
    input logic rxd_force,
    input logic rxd_drv
);

    // R2
    vs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_below |=> (!reg_en && !term_en && !weak_pu_en && !tx_path_en));

    // R7
    reg_off_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en && $past(!reg_en)) |-> !rst_out_n);

    // R3
    release_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (reg_en && $past(reg_en) && $past(!vcc_uv)));

    // R5
    path_needs_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_path_en && !rst_out_n) |=> !tx_path_en);

    // R8
    wake_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_en) && $past(weak_pu_en)) |-> term_en);

    // R1
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txd_oe |-> (!tx_path_en && rxd_force && !rxd_drv));

endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk u_chk (.*);

// File: tb/xcvr_mode_ctrl_test.sv
// Directed bench for the transceiver mode controller.
module xcvr_mode_ctrl_test;

    localparam int RST_T = 40;
    localparam int DEB_T = 5;
    localparam int LAG   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b1;
    logic en_pin = 1'b0;
    logic txd_pin = 1'b1;
    logic vs_above = 1'b0;
    logic vs_below = 1'b0;
    logic vcc_uv = 1'b0;
    logic wake_evt = 1'b0;
    logic tx_path_en, rx_path_en, reg_en, term_en, weak_pu_en, rst_out_n;
    logic txd_oe, txd_drv, rxd_force, rxd_drv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xcvr_mode_ctrl #(.RST_TICKS(RST_T), .DEB_TICKS(DEB_T), .SEL_LAG(LAG)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .en_pin(en_pin),
        .txd_pin(txd_pin), .vs_above(vs_above), .vs_below(vs_below),
        .vcc_uv(vcc_uv), .wake_evt(wake_evt), .tx_path_en(tx_path_en),
        .rx_path_en(rx_path_en), .reg_en(reg_en), .term_en(term_en),
        .weak_pu_en(weak_pu_en), .rst_out_n(rst_out_n), .txd_oe(txd_oe),
        .txd_drv(txd_drv), .rxd_force(rxd_force), .rxd_drv(rxd_drv)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        chk("R2", "reset reg_en", reg_en, 1'b0);
        chk("R2", "reset term_en", term_en, 1'b0);
        chk("R2", "reset rst_out_n", rst_out_n, 1'b0);
        chk("R2", "reset tx_path_en", tx_path_en, 1'b0);
    endtask

    task automatic t_powerup();
        vs_above = 1'b1;
        wait_cyc(3);
        chk("R1", "powerup reg_en", reg_en, 1'b1);
        chk("R1", "powerup term_en", term_en, 1'b1);
        chk("R1", "powerup txd_oe", txd_oe, 1'b1);
        chk("R1", "powerup txd_drv", txd_drv, 1'b1);
        chk("R1", "powerup rxd_force", rxd_force, 1'b1);
        chk("R1", "powerup rxd_drv", rxd_drv, 1'b0);
        en_pin = 1'b1;
        wait_cyc(RST_T - 12);
        chk("R3", "stretch still low", rst_out_n, 1'b0);
        chk("R5", "no normal while reset low", tx_path_en, 1'b0);
        wait_cyc(20);
        chk("R3", "stretch released", rst_out_n, 1'b1);
        wait_cyc(3);
        chk("R5", "normal after release", tx_path_en, 1'b1);
        chk("R9", "normal rx_path_en", rx_path_en, 1'b1);
        chk("R9", "normal term_en", term_en, 1'b1);
        chk("R9", "normal txd_oe", txd_oe, 1'b0);
        chk("R9", "normal rxd_force", rxd_force, 1'b0);
    endtask

    task automatic t_silent_and_wake();
        txd_pin = 1'b1;
        wait_cyc(8);
        en_pin = 1'b0;
        wait_cyc(8);
        chk("R6", "silent tx_path_en", tx_path_en, 1'b0);
        chk("R6", "silent term_en", term_en, 1'b0);
        chk("R6", "silent weak_pu_en", weak_pu_en, 1'b1);
        chk("R6", "silent reg_en", reg_en, 1'b1);
        chk("R6", "silent rxd_force", rxd_force, 1'b1);
        chk("R6", "silent rxd_drv", rxd_drv, 1'b1);
        wake_evt = 1'b1;
        wait_cyc(1);
        wake_evt = 1'b0;
        wait_cyc(2);
        chk("R8", "silent wake txd_oe", txd_oe, 1'b1);
        chk("R8", "silent wake txd_drv", txd_drv, 1'b0);
        chk("R8", "silent wake rxd_drv", rxd_drv, 1'b0);
        chk("R8", "silent wake term_en", term_en, 1'b1);
        chk("R8", "silent wake rst_out_n", rst_out_n, 1'b1);
        en_pin = 1'b1;
        wait_cyc(6);
        chk("R5", "back to normal", tx_path_en, 1'b1);
    endtask

    task automatic t_sleep_and_wake();
        txd_pin = 1'b0;
        wait_cyc(10);
        en_pin = 1'b0;
        wait_cyc(8);
        chk("R7", "sleep reg_en", reg_en, 1'b0);
        chk("R7", "sleep rst_out_n", rst_out_n, 1'b0);
        chk("R7", "sleep rxd_force", rxd_force, 1'b1);
        chk("R7", "sleep rxd_drv", rxd_drv, 1'b0);
        chk("R7", "sleep weak_pu_en", weak_pu_en, 1'b1);
        chk("R7", "sleep term_en", term_en, 1'b0);
        txd_pin = 1'b1;
        wake_evt = 1'b1;
        wait_cyc(1);
        wake_evt = 1'b0;
        wait_cyc(2);
        chk("R8", "sleep wake reg_en", reg_en, 1'b1);
        chk("R8", "sleep wake term_en", term_en, 1'b1);
        chk("R8", "sleep wake txd_drv", txd_drv, 1'b0);
        chk("R8", "sleep wake rst low", rst_out_n, 1'b0);
        wait_cyc(RST_T + 10);
        chk("R8", "sleep wake rst released", rst_out_n, 1'b1);
        chk("R5", "enable low keeps fail-safe", txd_oe, 1'b1);
        en_pin = 1'b1;
        wait_cyc(6);
        chk("R5", "normal after sleep wake", tx_path_en, 1'b1);
    endtask

    task automatic t_window();
        txd_pin = 1'b1;
        wait_cyc(8);
        en_pin  = 1'b0;
        txd_pin = 1'b0;
        wait_cyc(8);
        chk("R10", "same-cycle fall gives silent reg_en", reg_en, 1'b1);
        chk("R10", "same-cycle fall gives silent rxd_drv", rxd_drv, 1'b1);
        txd_pin = 1'b1;
        wake_evt = 1'b1;
        wait_cyc(1);
        wake_evt = 1'b0;
        en_pin = 1'b1;
        wait_cyc(6);
        chk("R10", "back to normal", tx_path_en, 1'b1);
    endtask

    task automatic t_undervoltage();
        vcc_uv = 1'b1;
        wait_cyc(DEB_T - 2);
        vcc_uv = 1'b0;
        wait_cyc(4);
        chk("R4", "glitch ignored rst", rst_out_n, 1'b1);
        chk("R4", "glitch ignored path", tx_path_en, 1'b1);
        vcc_uv = 1'b1;
        wait_cyc(20);
        chk("R4", "long uv rst low", rst_out_n, 1'b0);
        chk("R4", "long uv fail-safe", txd_oe, 1'b1);
        chk("R4", "long uv cause supply", txd_drv, 1'b1);
        vcc_uv = 1'b0;
        wait_cyc(RST_T + 10);
        chk("R3", "release after uv", rst_out_n, 1'b1);
        wait_cyc(3);
        chk("R5", "normal after uv", tx_path_en, 1'b1);
    endtask

    task automatic t_brownout();
        vs_above = 1'b0;
        vs_below = 1'b1;
        wait_cyc(2);
        chk("R2", "brownout reg_en", reg_en, 1'b0);
        chk("R2", "brownout tx_path_en", tx_path_en, 1'b0);
        chk("R2", "brownout rx_path_en", rx_path_en, 1'b0);
        chk("R2", "brownout rst_out_n", rst_out_n, 1'b0);
        vs_below = 1'b0;
        wait_cyc(3);
        chk("R2", "stays unpowered", reg_en, 1'b0);
        vs_above = 1'b1;
        wait_cyc(3);
        chk("R1", "repower fail-safe", txd_oe, 1'b1);
        chk("R1", "repower cause", txd_drv, 1'b1);
    endtask

    initial begin
        wait_cyc(4);
        t_reset_state();
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset_state();
        t_powerup();
        t_silent_and_wake();
        t_sleep_and_wake();
        t_window();
        t_undervoltage();
        t_brownout();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule